// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit control microprocessor fetches next. Each time the core offers an instruction (`step` high), the unit reads the six-bit major opcode in the top of the word, checks any branch condition against the source operand the core has already read from the register file, and works out the branch target. The target can be relative to the branch's own address, an absolute field in the word, the link register, or a register operand. When a call-type instruction is decoded, the unit also asks for a write of the link register.

The processor has one branch delay slot. A taken branch does not redirect the very next fetch. The instruction right after the branch runs first, and the target becomes the next PC only when that slot instruction is stepped. The unit holds the pending target in a register until then, including across cycles in which `step` is low. A control instruction that sits in a delay slot is not honoured.

Top module: `bnpc_unit`

## Requirements
- R1: After reset no branch is pending. With a non-control instruction (major opcode bits 31:26 = 000000), `next_pc` is `pc`+1 and `taken` and `link_we` are 0.
- R2: Opcode 110000 is taken when `src_val` differs from the zero-extended 5-bit value in bits 20:16. The target of every conditional branch is `pc` plus the sign-extended 16-bit word offset in bits 15:0, with the sum wrapping modulo 2^PC_W.
- R3: Opcode 110001 is taken when `src_val` equals the zero-extended 5-bit value in bits 20:16. All `src_val` bits take part in the comparison.
- R4: Opcode 110011 is taken when bit `instr[20:16]` of `src_val` is 1. Opcode 110010 is taken when that bit is 0.
- R5: Opcode 110010 with bits 25:16 all zero (source register 0, bit 0) is an unconditional jump. It is taken whatever `src_val` holds.
- R6: Opcodes 110101, 111000 and 111001 are always taken. Their target is the zero-extended 26-bit field in bits 25:0.
- R7: A taken 110101 or 111000 raises `link_we` with `link_data` = `pc`+2. No other instruction raises `link_we`.
- R8: Opcode 110100 (bit 25 either value) and opcode 110111 with bits 25:20 = 110110 are taken with target `lr_val`. Opcode 110111 with bits 25:20 = 110111 is taken with target `src_val`, the operand of the register named in bits 4:0. Opcode 110111 with any other bits 25:20 is not a control instruction.
- R9: In the step that takes a branch, `next_pc` is `pc`+1 (the delay slot). At the next step, `next_pc` is the saved target. While `step` is low in between, the target is held.
- R10: An instruction stepped in a delay slot never raises `taken` or `link_we`, whatever its opcode.
- R11: A conditional branch whose condition fails gives `next_pc` = `pc`+1, `taken` = 0, and arms no pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction at `pc` is executed this cycle |
| pc | input | PC_W | Address of the current instruction (word units) |
| instr | input | 32 | Current instruction word |
| src_val | input | DATA_W | Operand of the register named by the instruction |
| lr_val | input | PC_W | Current link register value |
| next_pc | output | PC_W | Address to fetch next |
| taken | output | 1 | Current instruction transfers control |
| link_we | output | 1 | Write link register |
| link_data | output | PC_W | Return address for the link write |

## Verification
The immediate compares are tried with operands equal to the immediate, differing only above bit 4, and differing in the low bits. This separates a full-width comparison from a truncated one. Bit tests use bit 31 and bit 0 with both polarities, and the unconditional-jump form is contrasted with the same bit test on a nonzero register, so a condition that ignores the register field shows up. Relative targets use positive, negative and wrapping offsets. Each branch form is followed by its delay slot, including one with idle cycles before it and one holding a call, which shows whether the saved target survives and whether a slot instruction is suppressed.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  localparam int INSN_W = 32;

  typedef enum logic [3:0] {
    K_NONE,
    K_BNE_I,
    K_BEQ_I,
    K_BCLR,
    K_BSET,
    K_CALL,
    K_BL,
    K_JABS,
    K_RET,
    K_SRET,
    K_JREG
  } kind_e;

  localparam logic [5:0] OP_BNE_I = 6'b110000;
  localparam logic [5:0] OP_BEQ_I = 6'b110001;
  localparam logic [5:0] OP_BCLR  = 6'b110010;
  localparam logic [5:0] OP_BSET  = 6'b110011;
  localparam logic [5:0] OP_RET   = 6'b110100;
  localparam logic [5:0] OP_CALL  = 6'b110101;
  localparam logic [5:0] OP_XJMP  = 6'b110111;
  localparam logic [5:0] OP_BL    = 6'b111000;
  localparam logic [5:0] OP_JABS  = 6'b111001;
  localparam logic [5:0] SUB_JREG = 6'b110111;
  localparam logic [5:0] SUB_SRET = 6'b110110;
endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
  import bnpc_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output kind_e             kind,
  output logic [4:0]        reg_fld,
  output logic [4:0]        imm_fld,
  output logic [15:0]       off_fld,
  output logic [25:0]       abs_fld
);
  logic [5:0] major;
  logic [5:0] sub;

  assign major   = instr[31:26];
  assign sub     = instr[25:20];
  assign reg_fld = instr[25:21];
  assign imm_fld = instr[20:16];
  assign off_fld = instr[15:0];
  assign abs_fld = instr[25:0];

  always_comb begin
    kind = K_NONE;
    case (major)
      OP_BNE_I: kind = K_BNE_I;
      OP_BEQ_I: kind = K_BEQ_I;
      OP_BCLR:  kind = K_BCLR;
      OP_BSET:  kind = K_BSET;
      OP_RET:   kind = K_RET;
      OP_CALL:  kind = K_CALL;
      OP_BL:    kind = K_BL;
      OP_JABS:  kind = K_JABS;
      OP_XJMP: begin
        if (sub == SUB_JREG)      kind = K_JREG;
        else if (sub == SUB_SRET) kind = K_SRET;
        else                      kind = K_NONE;
      end
      default:  kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  kind_e             kind,
  input  logic [4:0]        reg_fld,
  input  logic [4:0]        imm_fld,
  input  logic [DATA_W-1:0] src_val,
  output logic              cond_true
);
  logic [DATA_W-1:0] imm_ext;
  logic              sel_bit;
  logic              is_jump;

  assign imm_ext = DATA_W'(imm_fld);
  assign sel_bit = src_val[imm_fld];
  assign is_jump = (reg_fld == 5'd0) && (imm_fld == 5'd0);

  always_comb begin
    case (kind)
      K_BNE_I: cond_true = (src_val != imm_ext);
      K_BEQ_I: cond_true = (src_val == imm_ext);
      K_BCLR:  cond_true = is_jump || !sel_bit;
      K_BSET:  cond_true = sel_bit;
      K_CALL, K_BL, K_JABS, K_RET, K_SRET, K_JREG: cond_true = 1'b1;
      default: cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  kind_e             kind,
  input  logic [PC_W-1:0]   pc,
  input  logic [15:0]       off_fld,
  input  logic [25:0]       abs_fld,
  input  logic [PC_W-1:0]   lr_val,
  input  logic [DATA_W-1:0] src_val,
  output logic [PC_W-1:0]   target
);
  localparam int OFF_PAD = PC_W - 16;
  localparam int ABS_PAD = PC_W - 26;

  function automatic logic [PC_W-1:0] rel_tgt(logic [PC_W-1:0] base, logic [15:0] off);
    return base + {{OFF_PAD{off[15]}}, off};
  endfunction

  function automatic logic [PC_W-1:0] abs_tgt(logic [25:0] fld);
    return {{ABS_PAD{1'b0}}, fld};
  endfunction

  always_comb begin
    case (kind)
      K_BNE_I, K_BEQ_I, K_BCLR, K_BSET: target = rel_tgt(pc, off_fld);
      K_CALL, K_BL, K_JABS:             target = abs_tgt(abs_fld);
      K_RET, K_SRET:                    target = lr_val;
      K_JREG:                           target = src_val[PC_W-1:0];
      default:                          target = '0;
    endcase
  end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] instr,
  input  logic [DATA_W-1:0] src_val,
  input  logic [PC_W-1:0]   lr_val,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [PC_W-1:0]   link_data
);
  kind_e           kind;
  logic [4:0]      reg_fld;
  logic [4:0]      imm_fld;
  logic [15:0]     off_fld;
  logic [25:0]     abs_fld;
  logic            cond_true;
  logic [PC_W-1:0] target;

  logic            pend_q;
  logic [PC_W-1:0] tgt_q;
  logic            arm_evt;
  logic            slot_evt;
  logic            is_link;

  bnpc_decode u_dec (
    .instr   (instr),
    .kind    (kind),
    .reg_fld (reg_fld),
    .imm_fld (imm_fld),
    .off_fld (off_fld),
    .abs_fld (abs_fld)
  );

  bnpc_cond #(.DATA_W(DATA_W)) u_cond (
    .kind      (kind),
    .reg_fld   (reg_fld),
    .imm_fld   (imm_fld),
    .src_val   (src_val),
    .cond_true (cond_true)
  );

  bnpc_target #(.PC_W(PC_W), .DATA_W(DATA_W)) u_tgt (
    .kind    (kind),
    .pc      (pc),
    .off_fld (off_fld),
    .abs_fld (abs_fld),
    .lr_val  (lr_val),
    .src_val (src_val),
    .target  (target)
  );

  assign slot_evt  = step && pend_q;
  assign arm_evt   = step && !pend_q && cond_true;
  assign is_link   = (kind == K_CALL) || (kind == K_BL);

  assign taken     = arm_evt;
  assign link_we   = arm_evt && is_link;
  assign link_data = pc + PC_W'(2);
  assign next_pc   = pend_q ? tgt_q : pc + PC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (slot_evt) begin
      pend_q <= 1'b0;
    end else if (arm_evt) begin
      pend_q <= 1'b1;
      tgt_q  <= target;
    end
  end
endmodule

// File: rtl/bnpc_chk.sv
module bnpc_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            link_we,
  input logic [PC_W-1:0] link_data,
  input logic            pend_q,
  input logic [PC_W-1:0] tgt_q
);
  // R9
  slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> next_pc == pc + PC_W'(1));

  // R9
  arm_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> pend_q);

  // R9
  hold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !step) |=> (pend_q && $stable(tgt_q)));

  // R9
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && step) |-> next_pc == tgt_q);

  // R10
  slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && step) |-> (!taken && !link_we));

  // R7
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (taken && link_data == pc + PC_W'(2)));

  // R1
  idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !taken);
endmodule

bind bnpc_unit bnpc_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .pc        (pc),
  .next_pc   (next_pc),
  .taken     (taken),
  .link_we   (link_we),
  .link_data (link_data),
  .pend_q    (pend_q),
  .tgt_q     (tgt_q)
);

// File: tb/tb_bnpc_unit.sv
module tb_bnpc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] instr = '0;
  logic [31:0] src_val = '0;
  logic [31:0] lr_val = '0;
  logic [31:0] next_pc;
  logic        taken;
  logic        link_we;
  logic [31:0] link_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bnpc_unit dut (
    .clk(clk), .rst_n(rst_n), .step(step), .pc(pc), .instr(instr),
    .src_val(src_val), .lr_val(lr_val), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_data(link_data)
  );

  function automatic logic [31:0] enc_br(logic [5:0] op, logic [4:0] rs, logic [4:0] f5, logic [15:0] off);
    return {op, rs, f5, off};
  endfunction

  function automatic logic [31:0] enc_abs(logic [5:0] op, logic [25:0] t);
    return {op, t};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic s, logic [31:0] p, logic [31:0] i, logic [31:0] sv, logic [31:0] lr);
    @(negedge clk);
    step = s; pc = p; instr = i; src_val = sv; lr_val = lr;
    #1;
  endtask

  // Step one instruction, check the branch cycle, then step a plain slot instruction.
  task automatic branch_case(string tag, logic [31:0] p, logic [31:0] i, logic [31:0] sv,
                             logic [31:0] lr, logic exp_take, logic [31:0] exp_tgt, logic exp_link);
    apply(1'b1, p, i, sv, lr);
    chk({tag, " taken"}, {31'd0, taken}, {31'd0, exp_take});
    chk({tag, " next_pc in branch step (R9/R11)"}, next_pc, p + 32'd1);
    chk({tag, " link_we (R7)"}, {31'd0, link_we}, {31'd0, exp_link});
    if (exp_link) chk({tag, " link_data (R7)"}, link_data, p + 32'd2);
    apply(1'b1, p + 32'd1, 32'h0, 32'h0, 32'h0);
    chk({tag, " next_pc after slot"}, next_pc, exp_take ? exp_tgt : p + 32'd2);
    chk({tag, " slot taken (R10)"}, {31'd0, taken}, 32'd0);
    apply(1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_reset;
    apply(1'b0, 32'd100, 32'h0, 32'h0, 32'h0);
    chk("R1 reset next_pc", next_pc, 32'd101);
    chk("R1 reset taken", {31'd0, taken}, 32'd0);
    apply(1'b1, 32'd100, 32'h0, 32'hFFFF_FFFF, 32'h0);
    chk("R1 plain step link_we", {31'd0, link_we}, 32'd0);
    chk("R1 plain step next_pc", next_pc, 32'd101);
    apply(1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_bne;
    branch_case("R2 R11 bne equal", 32'h200, enc_br(6'b110000, 5'd3, 5'd5, 16'd8), 32'd5, 0, 1'b0, 0, 1'b0);
    branch_case("R2 bne low diff", 32'h200, enc_br(6'b110000, 5'd3, 5'd5, 16'd8), 32'd6, 0, 1'b1, 32'h208, 1'b0);
    branch_case("R2 bne neg off", 32'h1000, enc_br(6'b110000, 5'd3, 5'd0, 16'hFFF0), 32'd1, 0, 1'b1, 32'h0FF0, 1'b0);
    branch_case("R2 bne wrap", 32'h10, enc_br(6'b110000, 5'd3, 5'd0, 16'hFFE0), 32'd1, 0, 1'b1, 32'hFFFF_FFF0, 1'b0);
  endtask

  task automatic t_beq;
    branch_case("R3 beq equal", 32'h300, enc_br(6'b110001, 5'd4, 5'd31, 16'd3), 32'h1F, 0, 1'b1, 32'h303, 1'b0);
    branch_case("R3 beq high bits", 32'h300, enc_br(6'b110001, 5'd4, 5'd31, 16'd3), 32'h3F, 0, 1'b0, 0, 1'b0);
    branch_case("R3 R11 beq low diff", 32'h300, enc_br(6'b110001, 5'd4, 5'd7, 16'd3), 32'h6, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_bits;
    branch_case("R4 bset b31", 32'h400, enc_br(6'b110011, 5'd2, 5'd31, 16'd16), 32'h8000_0000, 0, 1'b1, 32'h410, 1'b0);
    branch_case("R4 bclr b31 set", 32'h400, enc_br(6'b110010, 5'd2, 5'd31, 16'd16), 32'h8000_0000, 0, 1'b0, 0, 1'b0);
    branch_case("R4 bclr b0 clear", 32'h400, enc_br(6'b110010, 5'd2, 5'd0, 16'd4), 32'hFFFF_FFFE, 0, 1'b1, 32'h404, 1'b0);
    branch_case("R4 bset b0 clear", 32'h400, enc_br(6'b110011, 5'd2, 5'd0, 16'd4), 32'hFFFF_FFFE, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_jump;
    branch_case("R5 jump r0 b0", 32'h500, enc_br(6'b110010, 5'd0, 5'd0, 16'd40), 32'h1, 0, 1'b1, 32'h528, 1'b0);
    branch_case("R5 contrast r1 b0", 32'h500, enc_br(6'b110010, 5'd1, 5'd0, 16'd40), 32'h1, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_abs;
    branch_case("R6 abs jump", 32'h600, enc_abs(6'b111001, 26'h3FF_FFFF), 0, 0, 1'b1, 32'h03FF_FFFF, 1'b0);
    branch_case("R6 R7 call", 32'h600, enc_abs(6'b110101, 26'h0012_345), 0, 0, 1'b1, 32'h0001_2345, 1'b1);
    branch_case("R6 R7 bl", 32'hFFFF_FFFF, enc_abs(6'b111000, 26'h80), 0, 0, 1'b1, 32'h80, 1'b1);
  endtask

  task automatic t_indirect;
    branch_case("R8 ret", 32'h700, {6'b110100, 26'h0}, 0, 32'h1234, 1'b1, 32'h1234, 1'b0);
    branch_case("R8 iret", 32'h700, {6'b110100, 1'b1, 25'h0}, 0, 32'h5678, 1'b1, 32'h5678, 1'b0);
    branch_case("R8 sret", 32'h700, {6'b110111, 6'b110110, 20'h0}, 32'h9, 32'h4444, 1'b1, 32'h4444, 1'b0);
    branch_case("R8 jreg", 32'h700, {6'b110111, 6'b110111, 15'h0, 5'd5}, 32'hABCD, 32'h4444, 1'b1, 32'hABCD, 1'b0);
    branch_case("R8 other sub", 32'h700, {6'b110111, 6'b000000, 20'h5}, 32'hABCD, 32'h4444, 1'b0, 0, 1'b0);
  endtask

  task automatic t_hold;
    apply(1'b1, 32'h800, enc_br(6'b110010, 5'd0, 5'd0, 16'd32), 0, 0);
    chk("R9 hold arm taken", {31'd0, taken}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      apply(1'b0, 32'h801, 32'h0, 0, 0);
      chk("R9 idle next_pc", next_pc, 32'h820);
    end
    apply(1'b1, 32'h801, 32'h0, 0, 0);
    chk("R9 hold redirect", next_pc, 32'h820);
    apply(1'b1, 32'h820, 32'h0, 0, 0);
    chk("R9 after redirect", next_pc, 32'h821);
    apply(1'b0, 32'h0, 32'h0, 0, 0);
  endtask

  task automatic t_slot_ctrl;
    apply(1'b1, 32'h900, enc_abs(6'b111001, 26'h50), 0, 0);
    chk("R10 arm", {31'd0, taken}, 32'd1);
    apply(1'b1, 32'h901, enc_abs(6'b110101, 26'h77), 0, 0);
    chk("R10 slot call taken", {31'd0, taken}, 32'd0);
    chk("R10 slot call link_we", {31'd0, link_we}, 32'd0);
    chk("R10 slot next_pc", next_pc, 32'h50);
    apply(1'b1, 32'h50, 32'h0, 0, 0);
    chk("R10 no late arm", next_pc, 32'h51);
    apply(1'b0, 32'h0, 32'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bne();
    t_beq();
    t_bits();
    t_jump();
    t_abs();
    t_indirect();
    t_hold();
    t_slot_ctrl();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule